// File: doc/BRIEF.md
# Multicycle Processor Main Controller

This block is the main sequencer for a processor datapath in which one instruction takes several clock cycles. Each cycle does at most one ALU operation, one register-file access or one memory access. The controller holds a 4-bit state register with ten live states. It reads the 6-bit opcode held in the instruction register and the ALU zero flag. It drives every datapath strobe and mux select as a function of the current state only. A small ALU-control decoder turns the 2-bit ALU mode and the 6-bit function field into a 4-bit ALU operation code.

Every instruction starts with the same two cycles: fetch, then decode. At the end of decode the controller branches on the opcode:

| Class | Opcode | States after decode | Total cycles |
|-------|--------|---------------------|--------------|
| Load | 100011 | address compute, read, writeback | 5 |
| Store | 101011 | address compute, write | 4 |
| Register-register | 000000 | execute, write back | 4 |
| Branch-if-equal | 000100 | compare | 3 |
| Jump | 000010 | target write | 3 |

After the last state of each class the controller returns to fetch. The datapath PC enable is the one output that also uses the zero flag. It is the unconditional PC write, OR'ed with the conditional PC write when zero is 1.

Top module: `mcCtrlTop`

## Requirements
- R1: While `rstN` is low the state code is 0 (fetch), and `memWrite`, `regWrite`, `irWrite`, `pcWrite`, `pcWriteCond` and `pcEn` are all 0.
- R2: In fetch (state code 0) the outputs are as follows, and the next state is decode (1):
  - `memRead`=1, `irWrite`=1, `pcWrite`=1 and `pcEn`=1.
  - `iOrD`=0, `aluSrcA`=0, `aluSrcB`=01, `pcSource`=00 and `aluOp`=00.
  - Every other strobe is 0.
- R3: In decode (state code 1) the outputs are `aluSrcA`=0, `aluSrcB`=11 and `aluOp`=00, and no strobe is asserted.
- R4: After decode the next state is chosen by opcode:
  - 100011 or 101011 go to address compute (2).
  - 000000 goes to execute (6).
  - 000100 goes to compare (8).
  - 000010 goes to jump (9).
  - Any other opcode goes back to fetch.
- R5: A load visits the states 0, 1, 2, 3, 4 and then returns to 0.
  - In state 2: `aluSrcA`=1, `aluSrcB`=10, `aluOp`=00.
  - In state 3: `memRead`=1, `iOrD`=1.
  - In state 4: `regWrite`=1, `memToReg`=1, `regDst`=0.
- R6: A store visits the states 0, 1, 2, 5 and then returns to 0. In state 5 the outputs are `memWrite`=1 and `iOrD`=1.
- R7: A register-register instruction visits the states 0, 1, 6, 7 and then returns to 0.
  - In state 6: `aluSrcA`=1, `aluSrcB`=00, `aluOp`=10.
  - In state 7: `regWrite`=1, `regDst`=1, `memToReg`=0.
- R8: A branch visits the states 0, 1, 8 and then returns to 0.
  - In state 8: `pcWriteCond`=1, `pcSource`=01, `aluSrcA`=1, `aluSrcB`=00, `aluOp`=01.
  - `pcEn` in state 8 equals `zero`.
- R9: A jump visits the states 0, 1, 9 and then returns to 0. In state 9 the outputs are `pcWrite`=1, `pcEn`=1 and `pcSource`=10.
- R10: The `aluCtl` code is set by `aluOp` and, for mode 10, by `funct`:
  - `aluOp` 00 gives 0010 (add), and 01 gives 0110 (subtract).
  - `aluOp` 10 decodes `funct`: 100000 gives 0010, 100010 gives 0110, 100100 gives 0000 (and), 100101 gives 0001 (or) and 101010 gives 0111 (set-less-than).
  - Any other case gives 0010.
- R11: No state asserts `memRead` and `memWrite` together, and no state asserts `pcWrite` and `pcWriteCond` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| funct | input | 6 | Function field of the held instruction |
| zero | input | 1 | ALU result-is-zero flag |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register load |
| iOrD | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| memToReg | output | 1 | Register write data select: 1 memory data register |
| regDst | output | 1 | Destination register select: 1 rd field, 0 rt field |
| regWrite | output | 1 | Register file write strobe |
| aluSrcA | output | 1 | ALU A select: 0 PC, 1 A register |
| aluSrcB | output | 2 | ALU B select: 0 B reg, 1 constant 4, 2 immediate, 3 shifted immediate |
| pcSource | output | 2 | PC source: 0 ALU, 1 ALU result register, 2 jump target |
| pcWrite | output | 1 | Unconditional PC write |
| pcWriteCond | output | 1 | PC write when zero is set |
| pcEn | output | 1 | Effective PC enable |
| aluOp | output | 2 | ALU mode: 00 add, 01 subtract, 10 function decode |
| aluCtl | output | 4 | Decoded ALU operation |
| stateCode | output | 4 | Current controller state |

## Verification
The bench runs every instruction class back to back. A behavioural model checks each visited state and every strobe in every cycle, so a swapped dispatch target or a wrong cycle count is caught at once. The branch is run with zero both set and clear, which separates a correct conditional PC enable from one that ignores the flag. The register-register class is driven with each known function code and one unknown code, so that every row of the ALU decode and its fallback is exercised. An unrecognized opcode is also applied to show that the controller returns to fetch straight after decode.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;
  localparam int OP_W      = 6;
  localparam int FUNCT_W   = 6;
  localparam int STATE_W   = 4;
  localparam int ALUCTL_W  = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_MEMADDR = 4'd2,
    ST_LDREAD  = 4'd3,
    ST_LDWB    = 4'd4,
    ST_STORE   = 4'd5,
    ST_REXEC   = 4'd6,
    ST_RDONE   = 4'd7,
    ST_BRANCH  = 4'd8,
    ST_JUMP    = 4'd9
  } ctrlState_e;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JMP   = 6'b000010;

  localparam logic [1:0] ALUOP_ADD  = 2'b00;
  localparam logic [1:0] ALUOP_SUB  = 2'b01;
  localparam logic [1:0] ALUOP_FUNC = 2'b10;

  localparam logic [ALUCTL_W-1:0] ALU_AND = 4'b0000;
  localparam logic [ALUCTL_W-1:0] ALU_OR  = 4'b0001;
  localparam logic [ALUCTL_W-1:0] ALU_ADD = 4'b0010;
  localparam logic [ALUCTL_W-1:0] ALU_SUB = 4'b0110;
  localparam logic [ALUCTL_W-1:0] ALU_SLT = 4'b0111;

  typedef struct packed {
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       iOrD;
    logic       memToReg;
    logic       regDst;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] pcSource;
    logic       pcWrite;
    logic       pcWriteCond;
    logic [1:0] aluOp;
  } ctrlStrobes_t;
endpackage

// File: rtl/mcCtrlSequencer.sv
module mcCtrlSequencer
  import mcCtrlPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  output ctrlState_e      state
);
  ctrlState_e nextState;

  always_comb begin
    nextState = ST_FETCH;
    unique case (state)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        case (opcode)
          OP_LOAD, OP_STORE: nextState = ST_MEMADDR;
          OP_RTYPE:          nextState = ST_REXEC;
          OP_BEQ:            nextState = ST_BRANCH;
          OP_JMP:            nextState = ST_JUMP;
          default:           nextState = ST_FETCH;
        endcase
      end
      ST_MEMADDR: begin
        if (opcode == OP_LOAD)       nextState = ST_LDREAD;
        else if (opcode == OP_STORE) nextState = ST_STORE;
        else                         nextState = ST_FETCH;
      end
      ST_LDREAD: nextState = ST_LDWB;
      ST_REXEC:  nextState = ST_RDONE;
      ST_LDWB, ST_STORE, ST_RDONE, ST_BRANCH, ST_JUMP: nextState = ST_FETCH;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nextState;
  end

  a_r3_decode_follows_fetch: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FETCH |=> state == ST_DECODE);
  a_r5_read_then_writeback: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_LDREAD |=> state == ST_LDWB);
  a_r7_exec_then_done: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_REXEC |=> state == ST_RDONE);
  a_r8_branch_returns: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BRANCH |=> state == ST_FETCH);
  a_r9_jump_returns: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_JUMP |=> state == ST_FETCH);
endmodule

// File: rtl/mcCtrlDecode.sv
module mcCtrlDecode
  import mcCtrlPkg::*;
(
  input  ctrlState_e   state,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    unique case (state)
      ST_FETCH: begin
        strobes.memRead = 1'b1;
        strobes.irWrite = 1'b1;
        strobes.pcWrite = 1'b1;
        strobes.aluSrcB = 2'b01;
        strobes.aluOp   = ALUOP_ADD;
      end
      ST_DECODE: begin
        strobes.aluSrcB = 2'b11;
        strobes.aluOp   = ALUOP_ADD;
      end
      ST_MEMADDR: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = 2'b10;
        strobes.aluOp   = ALUOP_ADD;
      end
      ST_LDREAD: begin
        strobes.memRead = 1'b1;
        strobes.iOrD    = 1'b1;
      end
      ST_LDWB: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = 1'b1;
      end
      ST_STORE: begin
        strobes.memWrite = 1'b1;
        strobes.iOrD     = 1'b1;
      end
      ST_REXEC: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluOp   = ALUOP_FUNC;
      end
      ST_RDONE: begin
        strobes.regWrite = 1'b1;
        strobes.regDst   = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluOp       = ALUOP_SUB;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSource    = 2'b01;
      end
      ST_JUMP: begin
        strobes.pcWrite  = 1'b1;
        strobes.pcSource = 2'b10;
      end
      default: strobes = '0;
    endcase
  end
endmodule

// File: rtl/mcAluCtl.sv
module mcAluCtl
  import mcCtrlPkg::*;
(
  input  logic [1:0]          aluOp,
  input  logic [FUNCT_W-1:0]  funct,
  output logic [ALUCTL_W-1:0] aluCtl
);
  always_comb begin
    aluCtl = ALU_ADD;
    case (aluOp)
      ALUOP_ADD: aluCtl = ALU_ADD;
      ALUOP_SUB: aluCtl = ALU_SUB;
      ALUOP_FUNC: begin
        case (funct)
          6'b100000: aluCtl = ALU_ADD;
          6'b100010: aluCtl = ALU_SUB;
          6'b100100: aluCtl = ALU_AND;
          6'b100101: aluCtl = ALU_OR;
          6'b101010: aluCtl = ALU_SLT;
          default:   aluCtl = ALU_ADD;
        endcase
      end
      default: aluCtl = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcCtrlTop.sv
module mcCtrlTop
  import mcCtrlPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [OP_W-1:0]     opcode,
  input  logic [FUNCT_W-1:0]  funct,
  input  logic                zero,
  output logic                memRead,
  output logic                memWrite,
  output logic                irWrite,
  output logic                iOrD,
  output logic                memToReg,
  output logic                regDst,
  output logic                regWrite,
  output logic                aluSrcA,
  output logic [1:0]          aluSrcB,
  output logic [1:0]          pcSource,
  output logic                pcWrite,
  output logic                pcWriteCond,
  output logic                pcEn,
  output logic [1:0]          aluOp,
  output logic [ALUCTL_W-1:0] aluCtl,
  output logic [STATE_W-1:0]  stateCode
);
  ctrlState_e   state;
  ctrlStrobes_t strobes;

  mcCtrlSequencer u_seq (.clk(clk), .rstN(rstN), .opcode(opcode), .state(state));
  mcCtrlDecode    u_dec (.state(state), .strobes(strobes));
  mcAluCtl        u_alu (.aluOp(strobes.aluOp), .funct(funct), .aluCtl(aluCtl));

  // Write strobes are held off for as long as reset is asserted.
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite & rstN;
  assign irWrite     = strobes.irWrite & rstN;
  assign iOrD        = strobes.iOrD;
  assign memToReg    = strobes.memToReg;
  assign regDst      = strobes.regDst;
  assign regWrite    = strobes.regWrite & rstN;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign pcSource    = strobes.pcSource;
  assign pcWrite     = strobes.pcWrite & rstN;
  assign pcWriteCond = strobes.pcWriteCond & rstN;
  assign pcEn        = pcWrite | (pcWriteCond & zero);
  assign aluOp       = strobes.aluOp;
  assign stateCode   = state;

  a_r11_single_mem_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));
  a_r11_single_pc_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pcWrite, pcWriteCond}));
  a_r8_compare_subtracts: assert property (@(posedge clk) disable iff (!rstN)
    pcWriteCond |-> aluCtl == ALU_SUB);
  a_r10_fetch_adds: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |-> aluCtl == ALU_ADD);
  a_r2_fetch_pc_enabled: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |-> pcEn);
endmodule

// File: tb/mcCtrlTop_tb.sv
`timescale 1ns/100ps
module mcCtrlTop_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic [5:0] funct = 6'd0;
  logic       zero = 1'b0;
  logic       memRead, memWrite, irWrite, iOrD, memToReg, regDst, regWrite, aluSrcA;
  logic [1:0] aluSrcB, pcSource, aluOp;
  logic       pcWrite, pcWriteCond, pcEn;
  logic [3:0] aluCtl, stateCode;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  mcCtrlTop u_dut (
    .clk(clk), .rstN(rstN), .opcode(opcode), .funct(funct), .zero(zero),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite), .iOrD(iOrD),
    .memToReg(memToReg), .regDst(regDst), .regWrite(regWrite), .aluSrcA(aluSrcA),
    .aluSrcB(aluSrcB), .pcSource(pcSource), .pcWrite(pcWrite),
    .pcWriteCond(pcWriteCond), .pcEn(pcEn), .aluOp(aluOp), .aluCtl(aluCtl),
    .stateCode(stateCode)
  );

  // Expected strobe vector per state, taken from the requirement table:
  // {memRead,memWrite,irWrite,iOrD,memToReg,regDst,regWrite,aluSrcA,
  //  aluSrcB[2],pcSource[2],pcWrite,pcWriteCond,aluOp[2]}
  function automatic logic [15:0] expStrobes(input int st);
    case (st)
      0: return {1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,1'b1,1'b0,2'b00};
      1: return {8'b0,2'b11,2'b00,1'b0,1'b0,2'b00};
      2: return {7'b0,1'b1,2'b10,2'b00,2'b00,2'b00};
      3: return {1'b1,1'b0,1'b0,1'b1,4'b0,2'b00,2'b00,2'b00,2'b00};
      4: return {4'b0,1'b1,1'b0,1'b1,1'b0,8'b0};
      5: return {1'b0,1'b1,1'b0,1'b1,4'b0,8'b0};
      6: return {7'b0,1'b1,2'b00,2'b00,2'b00,2'b10};
      7: return {5'b0,1'b1,1'b1,1'b0,8'b0};
      8: return {7'b0,1'b1,2'b00,2'b01,1'b0,1'b1,2'b01};
      9: return {8'b0,2'b00,2'b10,1'b1,1'b0,2'b00};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [3:0] expAluCtl(input logic [1:0] mode, input logic [5:0] fn);
    if (mode == 2'b01) return 4'b0110;
    if (mode != 2'b10) return 4'b0010;
    case (fn)
      6'b100010: return 4'b0110;
      6'b100100: return 4'b0000;
      6'b100101: return 4'b0001;
      6'b101010: return 4'b0111;
      default:   return 4'b0010;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, actual, expected);
    end
  endtask

  // Runs one instruction; the expected state walk is pushed to a queue
  // and every cycle is compared against the model at the falling edge.
  task automatic runInstr(input logic [5:0] op, input logic [5:0] fn, input logic z,
                          input string tag);
    int walk[$];
    logic [15:0] expV;
    logic [15:0] actV;
    walk.push_back(0);
    walk.push_back(1);
    case (op)
      6'b100011: begin walk.push_back(2); walk.push_back(3); walk.push_back(4); end
      6'b101011: begin walk.push_back(2); walk.push_back(5); end
      6'b000000: begin walk.push_back(6); walk.push_back(7); end
      6'b000100: walk.push_back(8);
      6'b000010: walk.push_back(9);
      default: ;
    endcase
    opcode = op;
    funct  = fn;
    zero   = z;
    while (walk.size() > 0) begin
      int st = walk.pop_front();
      #0.5;
      expV = expStrobes(st);
      actV = {memRead, memWrite, irWrite, iOrD, memToReg, regDst, regWrite, aluSrcA,
              aluSrcB, pcSource, pcWrite, pcWriteCond, aluOp};
      check(tag, "state", int'(stateCode), st);
      check(tag, "strobes", int'(actV), int'(expV));
      check(st == 8 ? "R8" : tag, "pcEn", int'(pcEn),
            int'(expV[3] | (expV[2] & z)));
      check(st == 6 ? "R10" : tag, "aluCtl", int'(aluCtl), int'(expAluCtl(expV[1:0], fn)));
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R1: reset holds fetch with all write strobes low
    check("R1", "state", int'(stateCode), 0);
    check("R1", "writes", int'({memWrite, regWrite, irWrite, pcWrite, pcWriteCond, pcEn}), 0);
    zero = 1'b1;
    #0.5;
    check("R1", "pcEn with zero", int'(pcEn), 0);
    @(negedge clk);
    rstN = 1'b1;
    runInstr(6'b100011, 6'b000000, 1'b0, "R5");
    runInstr(6'b101011, 6'b000000, 1'b1, "R6");
    runInstr(6'b000000, 6'b100000, 1'b0, "R7");
    runInstr(6'b000000, 6'b100010, 1'b1, "R10");
    runInstr(6'b000000, 6'b100100, 1'b0, "R10");
    runInstr(6'b000000, 6'b100101, 1'b0, "R10");
    runInstr(6'b000000, 6'b101010, 1'b0, "R10");
    runInstr(6'b000000, 6'b111111, 1'b0, "R10");
    runInstr(6'b000100, 6'b000000, 1'b1, "R8");
    runInstr(6'b000100, 6'b000000, 1'b0, "R8");
    runInstr(6'b000010, 6'b000000, 1'b0, "R9");
    runInstr(6'b111000, 6'b000000, 1'b0, "R4");
    runInstr(6'b000101, 6'b000000, 1'b1, "R4");
    runInstr(6'b100011, 6'b000000, 1'b1, "R2");
    runInstr(6'b000010, 6'b000000, 1'b1, "R3");
    runInstr(6'b101011, 6'b000000, 1'b0, "R11");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule